// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Acknowledge Unit

This block joins two eight-line interrupt controller cores into one sixteen-line system. The upper core (the slave) serves global lines 8 to 15. It has no path of its own to the processor: whenever it holds a winning request, that request is latched into line 2 of the lower core (the master) as an edge request. The master's arbitration result drives the single interrupt output to the processor.

When the processor asks for an acknowledge, the unit answers one cycle later with an 8-bit vector. It marks the winning lines in service in the master and, for a cascaded request, in the slave as well. When no line truly wins, it falls back to line 7 of the controller concerned. Automatic end-of-interrupt clears the in-service bits again right after the response, and can optionally rotate the priority order. A specific end-of-interrupt command clears one named line. Each in-service clear is reported as a one-cycle pulse that carries the global line number.

Sequencing is done by a four-state machine:
- `ST_IDLE` accepts a request. An acknowledge request moves it to `ST_RESPOND`. An end-of-interrupt request with no acknowledge request in the same cycle moves it to `ST_CMD_EOI`.
- `ST_RESPOND` presents the vector and, under auto end-of-interrupt, clears the master line. It goes to `ST_CLR_SLAVE` when a slave line was also acknowledged under auto end-of-interrupt, and otherwise returns to `ST_IDLE`.
- `ST_CLR_SLAVE` clears the slave line and returns to `ST_IDLE`.
- `ST_CMD_EOI` clears the commanded line and returns to `ST_IDLE`.

Top module: `cascade_pic_ack`

## Requirements
- R1: During and right after reset, `cpu_irq`, `ack_valid` and `clr_valid` are low, no request is pending and the priority offset is 0.
- R2: `cpu_irq` is high exactly when the master has an unmasked pending request that outranks all of its in-service lines. A mask bit of 1 hides the line, but an edge that arrives while the line is masked is still latched.
- R3: An edge-triggered line (`trig_level` bit 0) latches a rising edge, and an acknowledge clears that latched request. A level-triggered line (`trig_level` bit 1) follows its pin, keeps its request through an acknowledge, and requests again once its in-service bit is cleared.
- R4: An acknowledge request accepted in `ST_IDLE` gives `ack_valid` high for exactly the next cycle. For a master line n other than 2, the vector is `master_base`*8 + n.
- R5: Priority rank is (line − offset) mod 8, and rank 0 is the highest. A request wins only if its rank is strictly better than every in-service line of the same core, so lines that are in service block themselves and all lower-ranked lines.
- R6: A slave winner sets master line 2 within two clock edges, regardless of that line's trigger setting. Acknowledging master line 2 also acknowledges the slave winner, and the vector is `slave_base`*8 + slave line.
- R7: If master line 2 wins but the slave has no winner, the vector is `slave_base`*8 + 7 and the slave's state is unchanged.
- R8: If the master has no winner, the vector is `master_base`*8 + 7, no in-service bit changes, and no clear pulse follows.
- R9: With `auto_eoi` high, the response cycle pulses `clr_valid` with the acknowledged master line. For a cascaded acknowledge, the next cycle pulses global line 8 + slave line.
- R10: With `auto_eoi` and `rotate_aeoi` both high, each acknowledge sets that core's offset to the acknowledged line + 1, so that line becomes the lowest priority.
- R11: `eoi_req` accepted in `ST_IDLE` clears the in-service bit of global line `eoi_line` (bit 3 selects the slave), and pulses `clr_valid`/`clr_line` in the following cycle.
- R12: `ack_req` is ignored outside `ST_IDLE`. When `ack_req` and `eoi_req` arrive in the same idle cycle, the end-of-interrupt request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 16 | Request pins, global lines 0..15. Bit 2 is taken by the cascade and ignored. |
| trig_level | input | 16 | Per line: 1 = level-triggered, 0 = edge-triggered. Bit 2 is ignored. |
| irq_mask | input | 16 | Per line: 1 = masked |
| master_base | input | 5 | Upper vector bits for master lines |
| slave_base | input | 5 | Upper vector bits for slave lines |
| auto_eoi | input | 1 | Clear in-service bits automatically after each acknowledge |
| rotate_aeoi | input | 1 | Rotate priority on automatic end-of-interrupt |
| ack_req | input | 1 | Acknowledge request from the processor |
| ack_valid | output | 1 | Vector valid, one cycle after an accepted request |
| ack_vector | output | 8 | Acknowledge vector |
| cpu_irq | output | 1 | Interrupt request to the processor |
| eoi_req | input | 1 | Specific end-of-interrupt command |
| eoi_line | input | 4 | Global line for the command |
| clr_valid | output | 1 | In-service clear pulse |
| clr_line | output | 4 | Global line being cleared |

## Verification
The bench builds the block with its defaults: eight lines per core, the cascade on master line 2, and an 8-bit vector. Both spurious codes therefore land on line 7 of their controller and cannot be confused with the cascade line. With the offset starting at 0, a rotation after acknowledging line 3 visibly reorders lines 1 and 5, which is enough to show that R10 changes the outcome and is not merely recorded. The bench uses a level-triggered slave line that drops after being latched into master line 2, which brings the spurious-slave path within reach.

// File: rtl/cascade_pic_pkg.sv
package cascade_pic_pkg;

    // Acknowledge / clear sequencer states
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_RESPOND   = 2'd1,
        ST_CLR_SLAVE = 2'd2,
        ST_CMD_EOI   = 2'd3
    } ack_state_e;

endpackage

// File: rtl/cpic_resolver.sv
// Rotating first-set finder: rank p maps to line (p + rot) mod N.
module cpic_resolver #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    input  logic [W-1:0] rot,
    output logic         found,
    output logic [W-1:0] rank,
    output logic [W-1:0] line
);

    always_comb begin
        found = 1'b0;
        rank  = '0;
        line  = '0;
        // descending scan so the lowest rank is written last
        for (int p = N - 1; p >= 0; p--) begin
            if (vec[W'(p) + rot]) begin
                found = 1'b1;
                rank  = W'(p);
                line  = W'(p) + rot;
            end
        end
    end

endmodule

// File: rtl/cpic_core.sv
// One eight-line controller core stand-in: request latch, in-service
// register, rotation offset and winner resolution.
module cpic_core #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_pin,
    input  logic [N-1:0] lvl_sel,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] pulse_set,
    input  logic         ack_take,
    input  logic         clr_take,
    input  logic [W-1:0] clr_idx,
    input  logic         rot_load,
    input  logic [W-1:0] rot_val,
    output logic         win_valid,
    output logic [W-1:0] win_line
);

    logic [N-1:0] irr_q, isr_q, pin_q;
    logic [W-1:0] off_q;

    logic         req_found, isr_found;
    logic [W-1:0] req_rank, isr_rank, isr_line_unused;
    logic [N-1:0] ack_mask, clr_mask, rise, edge_next, irr_next, isr_next;

    cpic_resolver #(.N(N), .W(W)) u_req_pick (
        .vec   (irr_q & ~mask),
        .rot   (off_q),
        .found (req_found),
        .rank  (req_rank),
        .line  (win_line)
    );

    cpic_resolver #(.N(N), .W(W)) u_isr_pick (
        .vec   (isr_q),
        .rot   (off_q),
        .found (isr_found),
        .rank  (isr_rank),
        .line  (isr_line_unused)
    );

    assign win_valid = req_found && (!isr_found || (req_rank < isr_rank));

    always_comb begin
        ack_mask  = ack_take ? (N'(1) << win_line) : '0;
        clr_mask  = clr_take ? (N'(1) << clr_idx)  : '0;
        rise      = req_pin & ~pin_q;
        edge_next = (irr_q & ~ack_mask) | rise | (pulse_set & ~ack_mask);
        irr_next  = (lvl_sel & req_pin) | (~lvl_sel & edge_next);
        isr_next  = (isr_q | ack_mask) & ~clr_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irr_q <= '0;
            isr_q <= '0;
            pin_q <= '0;
            off_q <= '0;
        end else begin
            irr_q <= irr_next;
            isr_q <= isr_next;
            pin_q <= req_pin;
            if (rot_load) begin
                off_q <= rot_val;
            end
        end
    end

endmodule

// File: rtl/cascade_pic_ack.sv
module cascade_pic_ack
    import cascade_pic_pkg::*;
#(
    parameter int LINES     = 8,
    parameter int CASC_LINE = 2,
    parameter int VEC_W     = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [2*LINES-1:0]                irq_in,
    input  logic [2*LINES-1:0]                trig_level,
    input  logic [2*LINES-1:0]                irq_mask,
    input  logic [VEC_W-$clog2(LINES)-1:0]    master_base,
    input  logic [VEC_W-$clog2(LINES)-1:0]    slave_base,
    input  logic                              auto_eoi,
    input  logic                              rotate_aeoi,
    input  logic                              ack_req,
    output logic                              ack_valid,
    output logic [VEC_W-1:0]                  ack_vector,
    output logic                              cpu_irq,
    input  logic                              eoi_req,
    input  logic [$clog2(LINES):0]            eoi_line,
    output logic                              clr_valid,
    output logic [$clog2(LINES):0]            clr_line
);

    localparam int LINE_W = $clog2(LINES);
    localparam logic [LINES-1:0]  CASC_BIT = LINES'(1) << CASC_LINE;
    localparam logic [LINE_W-1:0] CASC_L   = LINE_W'(CASC_LINE);
    localparam logic [LINE_W-1:0] SPUR_L   = LINE_W'(LINES - 1);

    ack_state_e state_q, state_d;

    logic              m_valid, s_valid;
    logic [LINE_W-1:0] m_line, s_line;
    logic              accept_ack, m_take, s_take;
    logic [VEC_W-1:0]  vec_d, vec_q;
    logic              aeoi_q, m_hit_q, s_hit_q;
    logic [LINE_W-1:0] m_line_q, s_line_q;
    logic [LINE_W:0]   eoi_q;
    logic              m_clr, s_clr;

    // ---------------- controller cores ----------------
    cpic_core #(.N(LINES), .W(LINE_W)) u_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_pin   (irq_in[LINES-1:0] & ~CASC_BIT),
        .lvl_sel   (trig_level[LINES-1:0] & ~CASC_BIT),
        .mask      (irq_mask[LINES-1:0]),
        .pulse_set (s_valid ? CASC_BIT : '0),
        .ack_take  (m_take),
        .clr_take  (m_clr),
        .clr_idx   (clr_line[LINE_W-1:0]),
        .rot_load  (m_take && auto_eoi && rotate_aeoi),
        .rot_val   (m_line + LINE_W'(1)),
        .win_valid (m_valid),
        .win_line  (m_line)
    );

    cpic_core #(.N(LINES), .W(LINE_W)) u_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_pin   (irq_in[2*LINES-1:LINES]),
        .lvl_sel   (trig_level[2*LINES-1:LINES]),
        .mask      (irq_mask[2*LINES-1:LINES]),
        .pulse_set ('0),
        .ack_take  (s_take),
        .clr_take  (s_clr),
        .clr_idx   (clr_line[LINE_W-1:0]),
        .rot_load  (s_take && auto_eoi && rotate_aeoi),
        .rot_val   (s_line + LINE_W'(1)),
        .win_valid (s_valid),
        .win_line  (s_line)
    );

    // ---------------- acknowledge decode ----------------
    always_comb begin
        accept_ack = (state_q == ST_IDLE) && ack_req;
        m_take     = accept_ack && m_valid;
        s_take     = m_take && (m_line == CASC_L) && s_valid;
        if (!m_valid) begin
            vec_d = {master_base, SPUR_L};
        end else if (m_line == CASC_L) begin
            vec_d = s_valid ? {slave_base, s_line} : {slave_base, SPUR_L};
        end else begin
            vec_d = {master_base, m_line};
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ack_req) begin
                    state_d = ST_RESPOND;
                end else if (eoi_req) begin
                    state_d = ST_CMD_EOI;
                end
            end
            ST_RESPOND: begin
                state_d = (aeoi_q && s_hit_q) ? ST_CLR_SLAVE : ST_IDLE;
            end
            ST_CLR_SLAVE: state_d = ST_IDLE;
            ST_CMD_EOI:   state_d = ST_IDLE;
        endcase
    end

    // ---------------- captured transaction ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q    <= '0;
            aeoi_q   <= 1'b0;
            m_hit_q  <= 1'b0;
            s_hit_q  <= 1'b0;
            m_line_q <= '0;
            s_line_q <= '0;
            eoi_q    <= '0;
        end else if (state_q == ST_IDLE) begin
            if (ack_req) begin
                vec_q    <= vec_d;
                aeoi_q   <= auto_eoi;
                m_hit_q  <= m_take;
                s_hit_q  <= s_take;
                m_line_q <= m_line;
                s_line_q <= s_line;
            end else if (eoi_req) begin
                eoi_q <= eoi_line;
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        ack_valid = 1'b0;
        clr_valid = 1'b0;
        clr_line  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RESPOND: begin
                ack_valid = 1'b1;
                if (aeoi_q && m_hit_q) begin
                    clr_valid = 1'b1;
                    clr_line  = {1'b0, m_line_q};
                end
            end
            ST_CLR_SLAVE: begin
                clr_valid = 1'b1;
                clr_line  = {1'b1, s_line_q};
            end
            ST_CMD_EOI: begin
                clr_valid = 1'b1;
                clr_line  = eoi_q;
            end
        endcase
    end

    assign ack_vector = vec_q;
    assign cpu_irq    = m_valid;
    assign m_clr      = clr_valid && !clr_line[LINE_W];
    assign s_clr      = clr_valid &&  clr_line[LINE_W];

endmodule

// File: rtl/cascade_pic_ack_chk.sv
module cascade_pic_ack_chk #(
    parameter int LINES     = 8,
    parameter int CASC_LINE = 2,
    parameter int VEC_W     = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ack_req,
    input logic                  eoi_req,
    input logic                  ack_valid,
    input logic [VEC_W-1:0]      ack_vector,
    input logic                  cpu_irq,
    input logic [2*LINES-1:0]    irq_mask,
    input logic                  clr_valid,
    input logic [$clog2(LINES):0] clr_line
);

    localparam int LINE_W = $clog2(LINES);
    localparam logic [LINE_W:0] CASC_G = (LINE_W+1)'(CASC_LINE);

    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> !ack_valid); // R4

    AST_ACK_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(ack_req)); // R4

    AST_IRQ_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> !(&irq_mask[LINES-1:0])); // R2

    AST_AEOI_LINE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && clr_valid) |-> ((clr_line == {1'b0, ack_vector[LINE_W-1:0]}) || (clr_line == CASC_G))); // R9

    AST_SLAVE_AFTER_CASC: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid && clr_line[LINE_W] && !$past(eoi_req)) |-> ($past(clr_valid) && $past(clr_line) == CASC_G)); // R9

    AST_MASTER_CLR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid && !ack_valid && !clr_line[LINE_W]) |-> $past(eoi_req)); // R11

endmodule

bind cascade_pic_ack cascade_pic_ack_chk #(
    .LINES(LINES), .CASC_LINE(CASC_LINE), .VEC_W(VEC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_req    (ack_req),
    .eoi_req    (eoi_req),
    .ack_valid  (ack_valid),
    .ack_vector (ack_vector),
    .cpu_irq    (cpu_irq),
    .irq_mask   (irq_mask),
    .clr_valid  (clr_valid),
    .clr_line   (clr_line)
);

// File: tb/cascade_pic_ack_tb_top.sv
`timescale 1ns/1ps
module cascade_pic_ack_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] irq_in, trig_level, irq_mask;
    logic [4:0]  master_base, slave_base;
    logic        auto_eoi, rotate_aeoi, ack_req, eoi_req;
    logic [3:0]  eoi_line;
    logic        ack_valid, cpu_irq, clr_valid;
    logic [7:0]  ack_vector;
    logic [3:0]  clr_line;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk; // 250 MHz

    cascade_pic_ack dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .trig_level(trig_level),
        .irq_mask(irq_mask), .master_base(master_base), .slave_base(slave_base),
        .auto_eoi(auto_eoi), .rotate_aeoi(rotate_aeoi), .ack_req(ack_req),
        .ack_valid(ack_valid), .ack_vector(ack_vector), .cpu_irq(cpu_irq),
        .eoi_req(eoi_req), .eoi_line(eoi_line), .clr_valid(clr_valid),
        .clr_line(clr_line)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(logic aeoi, logic rot);
        rst_n = 1'b0; irq_in = '0; trig_level = '0; irq_mask = '0;
        master_base = 5'd4; slave_base = 5'd5;   // vectors 0x20.. and 0x28..
        auto_eoi = aeoi; rotate_aeoi = rot; ack_req = 0; eoi_req = 0; eoi_line = '0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    // raise ack_req at a negedge; sample the response cycle
    task automatic ack_once(string req, int exp_vec);
        ack_req = 1'b1;
        step(1);
        check(req, "ack_valid", int'(ack_valid), 1);
        check(req, "vector", int'(ack_vector), exp_vec);
        ack_req = 1'b0;
    endtask

    task automatic cmd_eoi(int line);
        eoi_req = 1'b1; eoi_line = 4'(line);
        step(1);
        check("R11", "eoi clr_valid", int'(clr_valid), 1);
        check("R11", "eoi clr_line", int'(clr_line), line);
        eoi_req = 1'b0;
        step(1);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; irq_in = 16'hFFFF; trig_level = '0; irq_mask = '0;
        master_base = 5'd4; slave_base = 5'd5; auto_eoi = 0; rotate_aeoi = 0;
        ack_req = 0; eoi_req = 0; eoi_line = '0;
        step(2);
        check("R1", "cpu_irq in reset", int'(cpu_irq), 0);
        check("R1", "ack_valid in reset", int'(ack_valid), 0);
        check("R1", "clr_valid in reset", int'(clr_valid), 0);
        irq_in = '0;
        rst_n = 1'b1;
        step(1);
        check("R1", "cpu_irq after reset", int'(cpu_irq), 0);
    endtask

    task automatic t_edge_nesting;
        do_reset(0, 0);
        irq_mask = 16'h0040;
        irq_in[6] = 1'b1;
        step(3);
        check("R2", "masked line raises irq", int'(cpu_irq), 0);
        irq_mask = '0;
        step(1);
        check("R2", "latched edge after unmask", int'(cpu_irq), 1);
        ack_once("R4", 8'h26);
        step(1);
        check("R3", "edge request cleared by ack", int'(cpu_irq), 0);
        irq_in[7] = 1'b1;
        step(2);
        check("R5", "lower line blocked by in-service", int'(cpu_irq), 0);
        irq_in[5] = 1'b1;
        step(2);
        check("R5", "higher line nests", int'(cpu_irq), 1);
        ack_once("R5", 8'h25);
        step(1);
        cmd_eoi(5);
        check("R5", "line 7 still blocked by 6", int'(cpu_irq), 0);
        cmd_eoi(6);
        check("R5", "line 7 after clearing 6", int'(cpu_irq), 1);
        ack_once("R3", 8'h27);
        step(1);
    endtask

    task automatic t_level;
        do_reset(0, 0);
        trig_level[4] = 1'b1;
        irq_in[4] = 1'b1;
        step(2);
        ack_once("R4", 8'h24);
        step(1);
        check("R3", "level line in service", int'(cpu_irq), 0);
        cmd_eoi(4);
        check("R3", "level request kept", int'(cpu_irq), 1);
        irq_in[4] = 1'b0;
        step(1);
        check("R3", "level request follows pin", int'(cpu_irq), 0);
    endtask

    task automatic t_cascade;
        do_reset(0, 0);
        irq_in[11] = 1'b1;
        step(3);
        check("R6", "slave request reaches cpu_irq", int'(cpu_irq), 1);
        ack_once("R6", 8'h2B);
        check("R6", "no clear without auto eoi", int'(clr_valid), 0);
        step(1);
        check("R6", "irq drops after cascaded ack", int'(cpu_irq), 0);
    endtask

    task automatic t_spur_slave;
        do_reset(0, 0);
        trig_level[9] = 1'b1;
        irq_in[9] = 1'b1;
        step(3);
        irq_in[9] = 1'b0;
        step(2);
        check("R7", "master line 2 still pending", int'(cpu_irq), 1);
        ack_once("R7", 8'h2F);
        step(1);
    endtask

    task automatic t_spur_master;
        do_reset(1, 0);
        step(2);
        check("R8", "idle cpu_irq", int'(cpu_irq), 0);
        ack_once("R8", 8'h27);
        check("R8", "no clear on spurious", int'(clr_valid), 0);
        step(1);
        check("R8", "no clear after spurious", int'(clr_valid), 0);
    endtask

    task automatic t_rotation;
        do_reset(1, 1);
        irq_in[1] = 1'b1; irq_in[3] = 1'b1;
        step(2);
        ack_once("R9", 8'h21);
        check("R9", "auto clr_valid", int'(clr_valid), 1);
        check("R9", "auto clr_line", int'(clr_line), 1);
        step(1);
        check("R9", "in-service cleared", int'(cpu_irq), 1);
        ack_once("R10", 8'h23);
        step(1);
        irq_in[1] = 1'b0; irq_in[3] = 1'b0;
        step(1);
        irq_in[1] = 1'b1; irq_in[5] = 1'b1;
        step(2);
        ack_once("R10", 8'h25);
        step(1);
    endtask

    task automatic t_aeoi_cascade;
        do_reset(1, 0);
        irq_in[14] = 1'b1;
        step(3);
        ack_once("R9", 8'h2E);
        check("R9", "master clear first", int'(clr_valid), 1);
        check("R9", "master clear line", int'(clr_line), 2);
        step(1);
        check("R9", "slave clear next", int'(clr_valid), 1);
        check("R9", "slave clear line", int'(clr_line), 14);
        step(1);
        check("R9", "clear sequence done", int'(clr_valid), 0);
        check("R9", "no irq after clears", int'(cpu_irq), 0);
    endtask

    task automatic t_ignore;
        do_reset(0, 0);
        irq_in[0] = 1'b1; irq_in[1] = 1'b1;
        step(2);
        ack_req = 1'b1;
        step(1);
        check("R12", "first response", int'(ack_vector), 8'h20);
        step(1);
        check("R12", "held ack ignored in response", int'(ack_valid), 0);
        ack_req = 1'b0;
        cmd_eoi(0);
        check("R12", "line 1 untouched", int'(cpu_irq), 1);
        ack_req = 1'b1; eoi_req = 1'b1; eoi_line = 4'd0;
        step(1);
        check("R12", "ack wins", int'(ack_vector), 8'h21);
        ack_req = 1'b0; eoi_req = 1'b0;
        step(1);
        check("R12", "eoi dropped", int'(clr_valid), 0);
    endtask

    initial begin
        t_reset();
        t_edge_nesting();
        t_level();
        t_cascade();
        t_spur_slave();
        t_spur_master();
        t_rotation();
        t_aeoi_cascade();
        t_ignore();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule